// File: doc/BRIEF.md
# Synchronous Serial Port Channel

One channel of a synchronous serial port that sits on a processor's memory-mapped data bus. The bit clock always arrives from the external device on `ser_clk`; the channel never produces its own. Incoming serial data is sampled on rising edges of that clock and outgoing data changes on falling edges. All serial inputs pass through two-flop synchronisers into the system clock domain, and edges of the serial clock are found there. Two instances side by side form a dual-channel port.

Receive and transmit each take a frame length of 8 or 16 bits and a bit order (most significant or least significant bit first), chosen separately per direction in the control register. A frame-sync input per direction marks the first bit of a frame. The transmitter raises `tx_ready` while it holds a word waiting to be sent, which acts as the handshake toward the external device; it sends only when that device answers with a frame sync.

The processor reaches three registers through a request/busy bus. A request (`bus_req` with `bus_we`, `bus_addr`, `bus_wdata`) completes in the first cycle in which `bus_busy` is low; the requester must hold every request signal stable until then, and read data on `bus_rdata` is valid in that completing cycle. Software can synchronise by polling the status register, by the `irq` level, or by enabling wait mode so that a data access simply stalls until it can complete. Address 0 is the data register (read: received word, write: word to send), address 1 the control register, address 2 the status register, address 3 reads zero.

Top module: `ser_chan_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 2 (bit 1 transmit-empty set, bit 0 receive-full clear), and `irq`, `tx_ready`, `tx_sdo` and `bus_busy` are 0.
- R2: A receive frame starts at the rising `ser_clk` edge on which `rx_fs` is high; that bit and the next ones on following rising edges are shifted in until 8 bits (control bit 3 clear) or 16 bits (control bit 3 set) are taken, then the word is stored in the data register and status bit 0 is set.
- R3: Control bit 4 selects receive order: clear means the first received bit is the most significant bit of the frame, set means it is the least significant bit.
- R4: After an 8-bit receive frame the data register's bits 15 to 8 read zero.
- R5: When `tx_fs` is high at a falling `ser_clk` edge and a word is waiting, that word is taken and its first bit appears on `tx_sdo` after that edge, the next bits after the following falling edges; length is 16 if control bit 0 is set, else 8 (low byte), and control bit 1 set means least significant bit first, clear means most significant first; after the last bit `tx_sdo` returns to 0.
- R6: `tx_ready` is high exactly while a written word waits to be sent; status bit 1 reads its inverse.
- R7: A completed read of address 0 clears status bit 0; a completed write of address 0 stores the word and marks it waiting.
- R8: `irq` equals (control bit 5 and status bit 0) or (control bit 2 and status bit 1).
- R9: With control bit 6 set, a read of address 0 while status bit 0 is clear, or a write of address 0 while a word waits, holds `bus_busy` high until a word arrives or the waiting word is taken, then completes.
- R10: With control bit 6 clear `bus_busy` stays low; a read of an empty data register returns the last received word, and a write while a word waits replaces it.
- R11: A `tx_fs` at a falling edge with no word waiting starts no frame: `tx_sdo` stays 0 and status bit 1 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request, held until accepted |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid when the access completes |
| bus_busy | output | 1 | Access stalled (wait mode) |
| irq | output | 1 | Level interrupt |
| ser_clk | input | 1 | External serial bit clock |
| rx_sdi | input | 1 | Serial receive data |
| rx_fs | input | 1 | Receive frame sync, high with the first bit |
| tx_sdo | output | 1 | Serial transmit data |
| tx_fs | input | 1 | Transmit frame sync from the external device |
| tx_ready | output | 1 | A word waits to be sent |

## Verification
A wrong bit counter or order flag shows as a misplaced or shifted word in the data register at the first read after a frame, or as wrong bits on `tx_sdo` within one serial clock period of the wrong edge. A stuck or mis-cleared buffer flag shows at the next status read, on `tx_ready` and on `irq` within a cycle, and in wait mode as a bus access that stalls too long or not at all. Random words, lengths and orders in both directions, together with directed stall, underrun and reset cases, make these visible at the ports.

// File: rtl/ser_chan_pkg.sv
package ser_chan_pkg;
  localparam int DATA_W = 16;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [1:0] A_DATA   = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;

  typedef struct packed {
    logic wait_en;   // bit 6
    logic rx_ie;     // bit 5
    logic rx_lsb;    // bit 4
    logic rx_long;   // bit 3
    logic tx_ie;     // bit 2
    logic tx_lsb;    // bit 1
    logic tx_long;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/ser_chan_sync.sv
module ser_chan_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage[s] <= '0;
        else if (s == 0) stage[s] <= d_i;
        else             stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q_o = stage[STAGES-1];
endmodule

// File: rtl/ser_chan_rx.sv
module ser_chan_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          sdi_i,
  input  logic          fs_i,
  input  logic          long_i,
  input  logic          lsb_i,
  output logic          done_o,
  output logic [DW-1:0] word_o
);
  localparam int SW = DW / 2;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] shreg, shnext, shfirst, assembled;
  logic [CW-1:0] cnt, flen;
  logic          active;

  always_comb begin
    flen      = long_i ? CW'(DW) : CW'(SW);
    shnext    = lsb_i ? {sdi_i, shreg[DW-1:1]} : {shreg[DW-2:0], sdi_i};
    shfirst   = lsb_i ? {sdi_i, {(DW-1){1'b0}}} : {{(DW-1){1'b0}}, sdi_i};
    if (long_i)     assembled = shnext;
    else if (lsb_i) assembled = {{SW{1'b0}}, shnext[DW-1:SW]};
    else            assembled = {{SW{1'b0}}, shnext[SW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      active <= 1'b0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        if (fs_i) begin
          shreg  <= shfirst;
          cnt    <= CW'(1);
          active <= 1'b1;
        end else if (active) begin
          shreg <= shnext;
          cnt   <= cnt + CW'(1);
          if (cnt + CW'(1) == flen) begin
            active <= 1'b0;
            done_o <= 1'b1;
            word_o <= assembled;
          end
        end
      end
    end
  end

  AST_RX_SHORT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !long_i) |-> (word_o[DW-1:SW] == '0)); // R4
  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < flen)); // R2
endmodule

// File: rtl/ser_chan_tx.sv
module ser_chan_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_i,
  input  logic          fs_i,
  input  logic          pend_i,
  input  logic [DW-1:0] pend_word_i,
  input  logic          long_i,
  input  logic          lsb_i,
  output logic          take_o,
  output logic          sdo_o
);
  localparam int SW = DW / 2;
  localparam int CW = $clog2(DW + 1);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] word;
  logic [CW-1:0] cnt, flen;
  logic [IW-1:0] first_idx, next_idx;
  logic          active;

  always_comb begin
    flen      = long_i ? CW'(DW) : CW'(SW);
    first_idx = lsb_i ? '0 : IW'(flen - CW'(1));
    next_idx  = lsb_i ? IW'(cnt) : IW'(flen - CW'(1) - cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      take_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else begin
      take_o <= 1'b0;
      if (fall_i) begin
        if (fs_i && pend_i) begin
          word   <= pend_word_i;
          cnt    <= CW'(1);
          active <= 1'b1;
          take_o <= 1'b1;
          sdo_o  <= pend_word_i[first_idx];
        end else if (fs_i) begin
          active <= 1'b0;
          sdo_o  <= 1'b0;
        end else if (active) begin
          if (cnt == flen) begin
            active <= 1'b0;
            sdo_o  <= 1'b0;
          end else begin
            sdo_o <= word[next_idx];
            cnt   <= cnt + CW'(1);
          end
        end
      end
    end
  end

  AST_TX_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(pend_i)); // R11
  AST_TX_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !take_o) |-> !sdo_o); // R5
endmodule

// File: rtl/ser_chan_top.sv
module ser_chan_top
  import ser_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_busy,
  output logic              irq,
  input  logic              ser_clk,
  input  logic              rx_sdi,
  input  logic              rx_fs,
  output logic              tx_sdo,
  input  logic              tx_fs,
  output logic              tx_ready
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] rx_buf, tx_buf, rx_word;
  logic              rx_full, tx_pend, rx_done, tx_take;
  logic [3:0]        ser_s;
  logic              sclk_prev, sclk_rise, sclk_fall;
  logic              data_sel, rd_acc, wr_acc;
  logic              unused_wdata_hi;

  ser_chan_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({tx_fs, rx_fs, rx_sdi, ser_clk}),
    .q_o   (ser_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= ser_s[0];
  end
  assign sclk_rise = ser_s[0] & ~sclk_prev;
  assign sclk_fall = ~ser_s[0] & sclk_prev;

  ser_chan_rx #(.DW(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (sclk_rise),
    .sdi_i  (ser_s[1]),
    .fs_i   (ser_s[2]),
    .long_i (ctrl.rx_long),
    .lsb_i  (ctrl.rx_lsb),
    .done_o (rx_done),
    .word_o (rx_word)
  );

  ser_chan_tx #(.DW(DATA_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_i      (sclk_fall),
    .fs_i        (ser_s[3]),
    .pend_i      (tx_pend),
    .pend_word_i (tx_buf),
    .long_i      (ctrl.tx_long),
    .lsb_i       (ctrl.tx_lsb),
    .take_o      (tx_take),
    .sdo_o       (tx_sdo)
  );

  assign data_sel = bus_req && (bus_addr == A_DATA);
  assign bus_busy = ctrl.wait_en && data_sel &&
                    ((!bus_we && !rx_full) || (bus_we && tx_pend));
  assign rd_acc   = data_sel && !bus_we && !bus_busy;
  assign wr_acc   = data_sel &&  bus_we && !bus_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      rx_buf  <= '0;
      tx_buf  <= '0;
      rx_full <= 1'b0;
      tx_pend <= 1'b0;
    end else begin
      if (bus_req && bus_we && bus_addr == A_CTRL)
        ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (rx_done) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
      end else if (rd_acc) begin
        rx_full <= 1'b0;
      end
      if (wr_acc) begin
        tx_buf  <= bus_wdata;
        tx_pend <= 1'b1;
      end else if (tx_take) begin
        tx_pend <= 1'b0;
      end
    end
  end

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTRL_W];

  always_comb begin
    case (bus_addr)
      A_DATA:   bus_rdata = rx_buf;
      A_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      A_STATUS: bus_rdata = {{(DATA_W-2){1'b0}}, ~tx_pend, rx_full};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq      = (ctrl.rx_ie && rx_full) || (ctrl.tx_ie && !tx_pend);
  assign tx_ready = tx_pend;

  AST_RX_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full); // R2
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !rx_done) |=> !rx_full); // R7
  AST_WRITE_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> tx_ready); // R6
  AST_NO_STALL_WITHOUT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.wait_en |-> !bus_busy); // R10
  AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !bus_we && !rx_done) |=> !rx_full); // R9
endmodule

// File: tb/test_ser_chan_top.sv
module test_ser_chan_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_busy, irq;
  logic        ser_clk = 1'b1, rx_sdi = 1'b0, rx_fs = 1'b0, tx_fs = 1'b0;
  logic        tx_sdo, tx_ready;

  int checks = 0, failures = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  ser_chan_top i_ser_chan_top (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_busy(bus_busy), .irq(irq), .ser_clk(ser_clk), .rx_sdi(rx_sdi),
    .rx_fs(rx_fs), .tx_sdo(tx_sdo), .tx_fs(tx_fs), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d, output bit stalled);
    stalled = 1'b0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    while (bus_busy) begin stalled = 1'b1; @(negedge clk); end
    d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] v, output bit stalled);
    stalled = 1'b0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    #1;
    while (bus_busy) begin stalled = 1'b1; @(negedge clk); end
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic frame_bit(input logic [15:0] w, input int n, input bit lsb, input int k);
    return lsb ? w[k] : w[n-1-k];
  endfunction

  // external device sends a frame into the channel
  task automatic rx_send(input logic [15:0] w, input int n, input bit lsb);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ser_clk = 1'b0; rx_sdi = frame_bit(w, n, lsb, k); rx_fs = (k == 0);
      half();
      ser_clk = 1'b1;
      half();
    end
    rx_fs = 1'b0; rx_sdi = 1'b0;
    half();
  endtask

  // external device requests a frame and collects n bits
  task automatic tx_collect(input int n, output logic [15:0] got);
    got = '0;
    @(negedge clk);
    tx_fs = 1'b1; ser_clk = 1'b0;
    half();
    tx_fs = 1'b0;
    for (int k = 0; k < n; k++) begin
      got[k] = tx_sdo;
      ser_clk = 1'b1; half();
      ser_clk = 1'b0; half();
    end
    chk(tx_sdo == 1'b0, "R5 line low after frame", tx_sdo, 0);
    ser_clk = 1'b1; half();
  endtask

  function automatic logic [15:0] expect_tx(input logic [15:0] w, input int n, input bit lsb);
    logic [15:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = frame_bit(w, n, lsb, k);
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, got, w;
    bit st;
    int n;
    bit lsb;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 0 && tx_ready == 0 && tx_sdo == 0 && bus_busy == 0, "R1 outputs", {irq, tx_ready, tx_sdo, bus_busy}, 0);
    bus_rd(2'd1, d, st); chk(d == 16'h0, "R1 ctrl", d, 0);
    bus_rd(2'd2, d, st); chk(d == 16'h2, "R1 status", d, 2);
    bus_rd(2'd3, d, st); chk(d == 16'h0, "R1 unused address", d, 0);

    // R11 underrun: no word waiting
    tx_collect(8, got);
    chk(got == 16'h0, "R11 no frame sent", got, 0);
    bus_rd(2'd2, d, st); chk(d[1] == 1'b1, "R11 still empty", d, 2);

    // R8 interrupt enables
    bus_wr(2'd1, 16'h0004, st);
    @(negedge clk); chk(irq == 1'b1, "R8 tx empty irq", irq, 1);
    bus_wr(2'd1, 16'h0020, st);
    @(negedge clk); chk(irq == 1'b0, "R8 rx irq idle", irq, 0);

    // random receive frames: R2 R3 R4 R7 R8
    for (int i = 0; i < 12; i++) begin
      w = 16'($urandom); n = ($urandom % 2) ? 16 : 8; lsb = 1'($urandom);
      bus_wr(2'd1, 16'h0020 | (n == 16 ? 16'h0008 : 16'h0) | (lsb ? 16'h0010 : 16'h0), st);
      rx_send(w, n, lsb);
      chk(irq == 1'b1, "R8 rx irq", irq, 1);
      bus_rd(2'd2, d, st); chk(d[0] == 1'b1, "R2 rx full", d, 1);
      bus_rd(2'd0, d, st);
      chk(d == (n == 16 ? w : {8'h0, w[7:0]}), lsb ? "R3 R2 rx word lsb-first" : "R2 rx word", d, (n == 16 ? w : {8'h0, w[7:0]}));
      if (n == 8) chk(d[15:8] == 8'h0, "R4 high byte zero", d, {8'h0, w[7:0]});
      bus_rd(2'd2, d, st); chk(d[0] == 1'b0, "R7 read clears full", d, 0);
    end

    // random transmit frames: R5 R6 R7
    for (int i = 0; i < 12; i++) begin
      w = 16'($urandom); n = ($urandom % 2) ? 16 : 8; lsb = 1'($urandom);
      bus_wr(2'd1, (n == 16 ? 16'h0001 : 16'h0) | (lsb ? 16'h0002 : 16'h0), st);
      bus_wr(2'd0, w, st);
      @(negedge clk); chk(tx_ready == 1'b1, "R6 ready while waiting", tx_ready, 1);
      bus_rd(2'd2, d, st); chk(d[1] == 1'b0, "R7 write marks waiting", d, 0);
      tx_collect(n, got);
      chk(got == expect_tx(w, n, lsb), "R5 tx bits", got, expect_tx(w, n, lsb));
      chk(tx_ready == 1'b0, "R6 ready drops", tx_ready, 0);
    end

    // R10 no wait: stale read, overwrite, never busy
    bus_wr(2'd1, 16'h0008, st);
    rx_send(16'hA55A, 16, 1'b0);
    bus_rd(2'd0, d, st);
    bus_rd(2'd0, d, st); chk(d == 16'hA55A && !st, "R10 stale read", d, 16'hA55A);
    bus_wr(2'd1, 16'h0001, st);
    bus_wr(2'd0, 16'h1111, st);
    bus_wr(2'd0, 16'h2222, st); chk(!st, "R10 write not stalled", st, 0);
    tx_collect(16, got);
    chk(got == expect_tx(16'h2222, 16, 1'b0), "R10 overwrite sent", got, expect_tx(16'h2222, 16, 1'b0));

    // R9 wait mode read stalls until a word arrives
    bus_wr(2'd1, 16'h0048, st);
    fork
      bus_rd(2'd0, d, st);
      rx_send(16'h3C96, 16, 1'b0);
    join
    chk(st, "R9 read stalled", st, 1);
    chk(d == 16'h3C96, "R9 stalled read data", d, 16'h3C96);

    // R9 wait mode write stalls until the waiting word is taken
    bus_wr(2'd1, 16'h0041, st);
    bus_wr(2'd0, 16'hBEEF, st);
    fork
      bus_wr(2'd0, 16'h7E01, st);
      tx_collect(16, got);
    join
    chk(st, "R9 write stalled", st, 1);
    chk(got == expect_tx(16'hBEEF, 16, 1'b0), "R9 first word sent", got, expect_tx(16'hBEEF, 16, 1'b0));
    chk(tx_ready == 1'b1, "R9 second word waiting", tx_ready, 1);
    tx_collect(16, got);
    chk(got == expect_tx(16'h7E01, 16, 1'b0), "R9 second word sent", got, expect_tx(16'h7E01, 16, 1'b0));

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule